// File: doc/BRIEF.md
# SPI Status Word Port with Clear-on-Read Flags

This block sits on the serial control port of a radio-style controller and answers status reads. The host sends 16-bit command frames over an SPI link. The first bit of each frame decides the frame's type. A leading zero makes the frame a status read. The block then freezes a 16-bit status word and returns it on the serial data output, most significant bit first. A leading one marks some other control command. Such frames belong to other blocks, so this port stays silent and leaves its flags alone.

The status word holds two kinds of bits. Event bits are latched when their event occurs and stay set until the host has read them: power-on, underrun or overflow, wake-up timeout, and a falling edge on the external interrupt pin. Level bits are copied live from their sources: low battery, FIFO empty, signal strength, data quality, clock lock, AFC toggle and the AFC frequency offset. Two further flags, transmit-register-ready and receive-FIFO-threshold, are cleared only by data-path events. A status read never clears them. If the host keeps clocking past the status word while chip select is low, the block streams receive-FIFO bytes and pops the FIFO once per byte. An active-low interrupt request stays asserted while any sticky flag is set.

Top module: `radio_status_port`

## Requirements
- R1: A frame whose first bit on `spi_mosi` is 0 is a status read. A frame whose first bit is 1 keeps `spi_miso` at 0 for the whole frame and clears no flag.
- R2: `spi_sclk`, `spi_cs_n`, `spi_mosi` and `ext_int_n` each pass through a `SYNC_STAGES`-flop synchronizer (default 2). A pin edge takes effect on the third rising `clk` edge after the pin changes. After the n-th rising edge of `spi_sclk` in a read frame (n = 1..16), `spi_miso` holds status bit 16-n. `spi_miso` is 0 while chip select is high.
- R3: The status word has this layout. Bit 15 is the ready/threshold flag, 14 power-on, 13 underrun/overflow, 12 wake-up, 11 external interrupt, 10 low battery, 9 FIFO empty, 8 antenna-tuned/RSSI, 7 data quality, 6 clock lock, 5 AFC toggle, 4 offset sign (`afc_sign`), and 3..0 the offset LSBs (`afc_lsb`).
- R4: With `tx_mode`=1, bit 15 shows the TX-ready flag, the underrun/overflow flag is set only by `underrun_evt`, and bit 8 shows `ant_tuned`. With `tx_mode`=0, bit 15 shows the FIFO-threshold flag, only `overflow_evt` sets the underrun/overflow flag, and bit 8 shows `rssi_above`.
- R5: The status word is captured at the first `spi_sclk` rising edge of a read frame. Inputs and events that change later do not alter the bits returned in that frame.
- R6: The power-on, underrun/overflow, wake-up and external flags are cleared when chip select rises after at least 16 `spi_sclk` rising edges of a status read. If chip select rises earlier, nothing is cleared.
- R7: That clear touches only the flags that were 1 in the captured word. A set event that arrives after the capture survives. A set event in the same clock cycle as the clear also wins over it.
- R8: The external flag is set by a high-to-low transition of `ext_int_n`. Holding the pin low, or a rising edge, does not set it again.
- R9: `tx_ready_evt` sets the TX-ready flag and `tx_write_evt` clears it, with set winning when both arrive together. A status read does not clear it.
- R10: `fifo_thresh_evt` sets the FIFO-threshold flag. It is cleared by `fifo_read_evt` or by a `fifo_pop` the block issues. A status read does not clear it.
- R11: In a read frame, `spi_sclk` rising edges 17, 25, 33, … each capture `fifo_rdata`, raise `fifo_pop` for one `clk` cycle, and start returning that byte MSB first, one bit per rising edge.
- R12: `irq_n` is registered. It goes to 0 one `clk` cycle after any of the six sticky flags (TX-ready, threshold, power-on, underrun/overflow, wake-up, external) is set, and to 1 one cycle after all are clear.
- R13: While `rst` is high, `irq_n` is 1, `spi_miso` and `fifo_pop` are 0, the power-on flag is set and every other flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| tx_mode | input | 1 | 1 = transmit view, 0 = receive view |
| tx_ready_evt | input | 1 | Pulse: TX register can take a byte |
| tx_write_evt | input | 1 | Pulse: TX register was written |
| fifo_thresh_evt | input | 1 | Pulse: RX FIFO reached its fill limit |
| fifo_read_evt | input | 1 | Pulse: FIFO read by another path |
| fifo_rdata | input | BYTE_W | Head byte of the RX FIFO |
| fifo_pop | output | 1 | One-cycle pop request to the RX FIFO |
| underrun_evt | input | 1 | Pulse: TX register underrun |
| overflow_evt | input | 1 | Pulse: RX FIFO overflow |
| wake_evt | input | 1 | Pulse: wake-up timer expired |
| ext_int_n | input | 1 | External interrupt pin, asynchronous |
| low_batt | input | 1 | Supply below limit |
| fifo_empty | input | 1 | RX FIFO empty |
| ant_tuned | input | 1 | Antenna tuning sees strong signal |
| rssi_above | input | 1 | Signal strength above limit |
| dq_ok | input | 1 | Data quality good |
| clk_locked | input | 1 | Clock recovery locked |
| afc_toggle | input | 1 | Toggles each AFC cycle |
| afc_sign | input | 1 | Sign of the AFC offset |
| afc_lsb | input | 4 | Low four bits of the AFC offset |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The critical collision is the end-of-read clear landing on the same clock edge as a fresh set of a flag that was shown in the word just read. The bench sets the wake-up flag and reads it. It then raises chip select and pulses `wake_evt` exactly on the edge where the synchronized chip-select rise is acted on. A follow-up read must still report the flag. The second collision is a TX-ready set and a TX-register write in one cycle, where the flag must end up set. Around these cases, events injected after the capture point and reads cut short before 16 bits confirm that clears reach only what was captured and only in completed reads.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int unsigned STAT_W  = 16;
  localparam int unsigned LSB_W   = 4;
  // bit positions inside the returned status word (order is behaviour)
  localparam int unsigned B_HEAD  = 15;
  localparam int unsigned B_POR   = 14;
  localparam int unsigned B_XRUN  = 13;
  localparam int unsigned B_WAKE  = 12;
  localparam int unsigned B_EXT   = 11;
  localparam int unsigned B_LBAT  = 10;
  localparam int unsigned B_FEMP  = 9;
  localparam int unsigned B_SIG   = 8;
  localparam int unsigned B_DQD   = 7;
  localparam int unsigned B_CRL   = 6;
  localparam int unsigned B_ATGL  = 5;
  localparam int unsigned B_SIGN  = 4;

  typedef struct packed {
    logic rdy;
    logic thr;
    logic por;
    logic xrun;
    logic wake;
    logic ext;
  } flag_t;

  localparam flag_t FLAG_RST = '{rdy: 1'b0, thr: 1'b0, por: 1'b1,
                                 xrun: 1'b0, wake: 1'b0, ext: 1'b0};
endpackage

// File: rtl/stw_sync.sv
module stw_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh <= {STAGES{RST_VAL[g]}};
      end else begin
        for (int s = STAGES - 1; s > 0; s--) sh[s] <= sh[s-1];
        sh[0] <= d[g];
      end
    end
    assign q[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/stw_flags.sv
module stw_flags
  import stw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_mode,
  input  logic       set_rdy,
  input  logic       clr_rdy,
  input  logic       set_thr,
  input  logic       clr_thr,
  input  logic       set_under,
  input  logic       set_over,
  input  logic       set_wake,
  input  logic       set_ext,
  input  logic       clr_read,
  input  logic [3:0] clr_mask,   // {por, xrun, wake, ext} as captured
  output flag_t      flags,
  output logic       irq_n
);
  flag_t nxt;

  always_comb begin
    nxt = flags;
    // clears first, sets afterwards so a same-cycle set wins
    if (clr_rdy) nxt.rdy = 1'b0;
    if (clr_thr) nxt.thr = 1'b0;
    if (clr_read) begin
      if (clr_mask[3]) nxt.por  = 1'b0;
      if (clr_mask[2]) nxt.xrun = 1'b0;
      if (clr_mask[1]) nxt.wake = 1'b0;
      if (clr_mask[0]) nxt.ext  = 1'b0;
    end
    if (set_rdy) nxt.rdy = 1'b1;
    if (set_thr) nxt.thr = 1'b1;
    if (tx_mode ? set_under : set_over) nxt.xrun = 1'b1;
    if (set_wake) nxt.wake = 1'b1;
    if (set_ext)  nxt.ext  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= FLAG_RST;
      irq_n <= 1'b1;
    end else begin
      flags <= nxt;
      irq_n <= ~(|flags);
    end
  end
endmodule

// File: rtl/stw_frame.sv
module stw_frame
  import stw_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              cs_q,
  input  logic              cs_rise,
  input  logic              mosi_q,
  input  logic [WORD_W-1:0] word_in,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              miso,
  output logic              fifo_pop,
  output logic              clr_read,
  output logic [3:0]        clr_mask
);
  localparam int unsigned CNT_W = $clog2(WORD_W + BYTE_W);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W + BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic              reading, done;
  logic [WORD_W-1:0] sr, sr_nxt;
  logic              start, load_byte, reading_nxt;

  assign start       = sclk_rise && !cs_q && (cnt == '0);
  assign load_byte   = sclk_rise && !cs_q && reading && (cnt == CNT_WORD);
  assign reading_nxt = start ? !mosi_q : reading;

  always_comb begin
    sr_nxt = sr;
    if (start && !mosi_q)          sr_nxt = word_in;
    else if (load_byte)            sr_nxt = {fifo_data, {(WORD_W-BYTE_W){1'b0}}};
    else if (sclk_rise && reading) sr_nxt = {sr[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || cs_q) begin
      cnt      <= '0;
      reading  <= 1'b0;
      done     <= 1'b0;
      sr       <= '0;
      miso     <= 1'b0;
      fifo_pop <= 1'b0;
      if (rst) clr_mask <= '0;
    end else begin
      fifo_pop <= load_byte;
      if (sclk_rise) begin
        cnt     <= (cnt == CNT_LAST) ? CNT_WORD : cnt + 1'b1;
        if (cnt == CNT_PRE) done <= 1'b1;
        reading <= reading_nxt;
        sr      <= sr_nxt;
        miso    <= reading_nxt & sr_nxt[WORD_W-1];
        if (start && !mosi_q) clr_mask <= word_in[B_POR:B_EXT];
      end
    end
  end

  assign clr_read = cs_rise && reading && done;
endmodule

// File: rtl/radio_status_port.sv
module radio_status_port
  import stw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              tx_mode,
  input  logic              tx_ready_evt,
  input  logic              tx_write_evt,
  input  logic              fifo_thresh_evt,
  input  logic              fifo_read_evt,
  input  logic [BYTE_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  input  logic              underrun_evt,
  input  logic              overflow_evt,
  input  logic              wake_evt,
  input  logic              ext_int_n,
  input  logic              low_batt,
  input  logic              fifo_empty,
  input  logic              ant_tuned,
  input  logic              rssi_above,
  input  logic              dq_ok,
  input  logic              clk_locked,
  input  logic              afc_toggle,
  input  logic              afc_sign,
  input  logic [LSB_W-1:0]  afc_lsb,
  output logic              irq_n
);
  // synchronized pins: {ext, cs_n, sclk, mosi}
  logic [3:0] syn;
  logic [2:0] edge_q;   // previous {ext, cs_n, sclk}
  logic sclk_rise, cs_rise, ext_fall, cs_q, mosi_q;

  stw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_int_n, spi_cs_n, spi_sclk, spi_mosi}),
    .q   (syn)
  );

  always_ff @(posedge clk) begin
    if (rst) edge_q <= 3'b110;
    else     edge_q <= syn[3:1];
  end

  assign mosi_q    = syn[0];
  assign cs_q      = syn[2];
  assign sclk_rise = syn[1] & ~edge_q[0];
  assign cs_rise   = syn[2] & ~edge_q[1];
  assign ext_fall  = ~syn[3] & edge_q[2];

  flag_t flags;
  logic  clr_read, pop_w;
  logic [3:0] clr_mask;
  logic [STAT_W-1:0] word;

  always_comb begin
    word         = '0;
    word[B_HEAD] = tx_mode ? flags.rdy : flags.thr;
    word[B_POR]  = flags.por;
    word[B_XRUN] = flags.xrun;
    word[B_WAKE] = flags.wake;
    word[B_EXT]  = flags.ext;
    word[B_LBAT] = low_batt;
    word[B_FEMP] = fifo_empty;
    word[B_SIG]  = tx_mode ? ant_tuned : rssi_above;
    word[B_DQD]  = dq_ok;
    word[B_CRL]  = clk_locked;
    word[B_ATGL] = afc_toggle;
    word[B_SIGN] = afc_sign;
    word[LSB_W-1:0] = afc_lsb;
  end

  stw_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .tx_mode   (tx_mode),
    .set_rdy   (tx_ready_evt),
    .clr_rdy   (tx_write_evt),
    .set_thr   (fifo_thresh_evt),
    .clr_thr   (fifo_read_evt | pop_w),
    .set_under (underrun_evt),
    .set_over  (overflow_evt),
    .set_wake  (wake_evt),
    .set_ext   (ext_fall),
    .clr_read  (clr_read),
    .clr_mask  (clr_mask),
    .flags     (flags),
    .irq_n     (irq_n)
  );

  stw_frame #(.WORD_W(STAT_W), .BYTE_W(BYTE_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .cs_q      (cs_q),
    .cs_rise   (cs_rise),
    .mosi_q    (mosi_q),
    .word_in   (word),
    .fifo_data (fifo_rdata),
    .miso      (spi_miso),
    .fifo_pop  (pop_w),
    .clr_read  (clr_read),
    .clr_mask  (clr_mask)
  );

  assign fifo_pop = pop_w;
endmodule

// File: rtl/stw_checker.sv
module stw_checker
  import stw_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  cs_q,
  input logic  miso,
  input logic  fifo_pop,
  input logic  irq_n,
  input flag_t flags,
  input logic  ext_fall,
  input logic  tx_ready_evt,
  input logic  tx_write_evt
);
  p_idle_miso_r2: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !miso);

  p_pop_single_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  p_irq_set_r12: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> !irq_n);

  p_irq_clr_r12: assert property (@(posedge clk) disable iff (rst)
    !(|flags) |=> irq_n);

  p_ext_set_r8: assert property (@(posedge clk) disable iff (rst)
    ext_fall |=> flags.ext);

  p_rdy_set_r9: assert property (@(posedge clk) disable iff (rst)
    tx_ready_evt |=> flags.rdy);

  p_rdy_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_write_evt && !tx_ready_evt) |=> !flags.rdy);
endmodule

bind radio_status_port stw_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .cs_q         (cs_q),
  .miso         (spi_miso),
  .fifo_pop     (fifo_pop),
  .irq_n        (irq_n),
  .flags        (flags),
  .ext_fall     (ext_fall),
  .tx_ready_evt (tx_ready_evt),
  .tx_write_evt (tx_write_evt)
);

// File: tb/radio_status_port_tb_top.sv
module radio_status_port_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic tx_mode = 1'b0;
  logic tx_ready_evt = 0, tx_write_evt = 0, fifo_thresh_evt = 0, fifo_read_evt = 0;
  logic [7:0] fifo_rdata = 8'h00;
  logic fifo_pop;
  logic underrun_evt = 0, overflow_evt = 0, wake_evt = 0, ext_int_n = 1;
  logic low_batt = 0, fifo_empty = 0, ant_tuned = 0, rssi_above = 0;
  logic dq_ok = 0, clk_locked = 0, afc_toggle = 0, afc_sign = 0;
  logic [3:0] afc_lsb = 4'h0;
  logic irq_n;

  int checks = 0;
  int fails  = 0;
  int pops   = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (fifo_pop) pops <= pops + 1;

  radio_status_port dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .tx_mode(tx_mode), .tx_ready_evt(tx_ready_evt),
    .tx_write_evt(tx_write_evt), .fifo_thresh_evt(fifo_thresh_evt),
    .fifo_read_evt(fifo_read_evt), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .underrun_evt(underrun_evt), .overflow_evt(overflow_evt), .wake_evt(wake_evt),
    .ext_int_n(ext_int_n), .low_batt(low_batt), .fifo_empty(fifo_empty),
    .ant_tuned(ant_tuned), .rssi_above(rssi_above), .dq_ok(dq_ok),
    .clk_locked(clk_locked), .afc_toggle(afc_toggle), .afc_sign(afc_sign),
    .afc_lsb(afc_lsb), .irq_n(irq_n)
  );

  // lvl = {low_batt, fifo_empty, ant_tuned, rssi_above, dq_ok, clk_locked, afc_toggle}
  // ev  = {head flag, xrun, wake, ext}
  typedef struct packed {
    logic       mode;
    logic [6:0] lvl;
    logic       sign;
    logic [3:0] lsb;
    logic [3:0] ev;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 7'b1010101, 1'b1, 4'h5, 4'b1010},
    '{1'b0, 7'b0101010, 1'b0, 4'hA, 4'b0101},
    '{1'b1, 7'b0010000, 1'b1, 4'h0, 4'b1111},
    '{1'b0, 7'b0001000, 1'b0, 4'hF, 4'b0000},
    '{1'b0, 7'b1111111, 1'b1, 4'hF, 4'b1100},
    '{1'b1, 7'b0000000, 1'b0, 4'h0, 4'b0011}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic ext_fall_pin;
    @(negedge clk); ext_int_n = 1'b0;
    repeat (6) @(negedge clk);
    ext_int_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Runs one frame; when collide is set the wake event lands on the clear edge.
  task automatic spi_xfer(input logic [15:0] cmd, input int nbits,
                          input bit collide, output logic [31:0] rx);
    rx = '0;
    @(negedge clk); cs_n = 1'b0; sclk = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H-1) @(negedge clk);
      rx = {rx[30:0], miso};
      @(negedge clk); sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    if (collide) begin
      @(posedge clk); @(posedge clk);
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic read16(output logic [15:0] w);
    logic [31:0] rx;
    spi_xfer(16'h0000, 16, 1'b0, rx);
    w = rx[15:0];
  endtask

  function automatic logic [15:0] expect_word(input vec_t v, input logic por);
    return {v.ev[3], por, v.ev[2], v.ev[1], v.ev[0], v.lvl[6], v.lvl[5],
            (v.mode ? v.lvl[4] : v.lvl[3]), v.lvl[2], v.lvl[1], v.lvl[0],
            v.sign, v.lsb};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [31:0] rx;
    int p0;

    // R13 reset state
    repeat (5) @(negedge clk);
    chk("R13", "irq_n in reset", 32'(irq_n), 32'd1);
    chk("R13", "miso in reset", 32'(miso), 32'd0);
    chk("R13", "pop in reset", 32'(fifo_pop), 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "irq_n with power-on flag", 32'(irq_n), 32'd0);

    // table walk: R3 R4 R6 R13
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tx_mode = VECS[i].mode;
      {low_batt, fifo_empty, ant_tuned, rssi_above, dq_ok, clk_locked, afc_toggle} = VECS[i].lvl;
      afc_sign = VECS[i].sign; afc_lsb = VECS[i].lsb;
      if (VECS[i].ev[3] == VECS[i].mode) pulse(tx_ready_evt); else pulse(fifo_thresh_evt);
      if (VECS[i].ev[2] == VECS[i].mode) pulse(underrun_evt); else pulse(overflow_evt);
      if (VECS[i].ev[1]) pulse(wake_evt);
      if (VECS[i].ev[0]) ext_fall_pin();
      repeat (4) @(negedge clk);
      read16(w);
      chk("R3/R4", $sformatf("vector %0d word", i), 32'(w),
          32'(expect_word(VECS[i], i == 0)));
      @(negedge clk); tx_write_evt = 1'b1; fifo_read_evt = 1'b1;
      @(negedge clk); tx_write_evt = 1'b0; fifo_read_evt = 1'b0;
      repeat (4) @(negedge clk);
    end
    {low_batt, fifo_empty, ant_tuned, rssi_above, dq_ok, clk_locked, afc_toggle} = 7'd0;
    afc_sign = 1'b0; afc_lsb = 4'h0; tx_mode = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "irq_n all clear", 32'(irq_n), 32'd1);
    read16(w);
    chk("R6", "latched flags cleared by previous read", 32'(w), 32'h0000);

    // R1 non-read frame: silent, no clear
    pulse(wake_evt);
    repeat (3) @(negedge clk);
    chk("R12", "irq_n after wake event", 32'(irq_n), 32'd0);
    spi_xfer(16'h8000, 16, 1'b0, rx);
    chk("R1", "miso during non-read frame", rx, 32'h0);
    read16(w);
    chk("R1", "wake kept after non-read frame", 32'(w[12]), 32'd1);

    // R6 aborted read does not clear
    pulse(wake_evt);
    spi_xfer(16'h0000, 10, 1'b0, rx);
    chk("R2", "first ten bits of aborted read", rx[9:0], 32'(10'b0001000000));
    read16(w);
    chk("R6", "wake kept after aborted read", 32'(w[12]), 32'd1);
    read16(w);
    chk("R6", "wake cleared after full read", 32'(w[12]), 32'd0);

    // R5/R7 event and level change after capture
    fork
      read16(w);
      begin
        repeat (3) @(posedge sclk);
        @(negedge clk); low_batt = 1'b1; wake_evt = 1'b1;
        @(negedge clk); wake_evt = 1'b0;
      end
    join
    chk("R5", "word frozen at capture", 32'(w), 32'h0000);
    read16(w);
    chk("R7", "late event survives clear", 32'(w), 32'h1400);
    low_batt = 1'b0;
    read16(w);
    chk("R7", "flag cleared once shown", 32'(w), 32'h0000);

    // R7 collision: wake set on the clear edge
    pulse(wake_evt);
    spi_xfer(16'h0000, 16, 1'b1, rx);
    chk("R7", "word before collision", rx[15:0], 32'h1000);
    read16(w);
    chk("R7", "set wins over read clear", 32'(w[12]), 32'd1);
    read16(w);

    // R8 pin held low sets once
    @(negedge clk); ext_int_n = 1'b0;
    repeat (6) @(negedge clk);
    read16(w);
    chk("R8", "falling edge sets ext", 32'(w[11]), 32'd1);
    read16(w);
    chk("R8", "held low does not re-set", 32'(w[11]), 32'd0);
    ext_int_n = 1'b1;
    repeat (6) @(negedge clk);
    read16(w);
    chk("R8", "rising edge does not set", 32'(w[11]), 32'd0);

    // R9 set/clear collision and read immunity
    @(negedge clk); tx_ready_evt = 1'b1; tx_write_evt = 1'b1;
    @(negedge clk); tx_ready_evt = 1'b0; tx_write_evt = 1'b0;
    read16(w);
    chk("R9", "set wins over write", 32'(w[15]), 32'd1);
    read16(w);
    chk("R9", "status read leaves ready", 32'(w[15]), 32'd1);
    pulse(tx_write_evt);
    read16(w);
    chk("R9", "write clears ready", 32'(w[15]), 32'd0);

    // R10/R11 FIFO continuation in receive view
    tx_mode = 1'b0;
    pulse(fifo_thresh_evt);
    read16(w);
    chk("R10", "threshold survives status read", 32'(w[15]), 32'd1);
    p0 = pops;
    fifo_rdata = 8'hC3;
    fork
      spi_xfer(16'h0000, 32, 1'b0, rx);
      begin
        repeat (18) @(posedge sclk);
        @(negedge clk); fifo_rdata = 8'h5A;
      end
    join
    chk("R11", "status part", 32'(rx[31:16]), 32'h8000);
    chk("R11", "first fifo byte", 32'(rx[15:8]), 32'hC3);
    chk("R11", "second fifo byte", 32'(rx[7:0]), 32'h5A);
    chk("R11", "pop count", 32'(pops - p0), 32'd2);
    read16(w);
    chk("R10", "pop cleared threshold", 32'(w[15]), 32'd0);
    repeat (3) @(negedge clk);
    chk("R12", "irq_n released", 32'(irq_n), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule